// File: doc/BRIEF.md
# OLED Panel Power-Up and Refresh Sequencer

This block brings up a 128x32 monochrome OLED module and then streams pixel bytes to it over a write-only serial link. The link has a clock, a data line, a chip select and a data/command select line. After reset the block follows a fixed, timed order. It enables the logic supply, waits, and pulses the controller reset low. It then sends the configuration commands, enables the panel supply and waits for it to settle. Next it writes zeros to the whole display memory and sends the display-on command. Only after that does it raise `ready`.

Once `ready` is high, a client offers a byte on `wr_data` with `wr_en`. The block takes the byte on a clock edge where `busy` is low. It sends the byte as pixel data, with D/C high and one bit per pixel. All delays come from the `CLK_HZ` parameter, so a bench can shorten them by giving a small value. The serial clock runs at `CLK_HZ / SCLK_DIV`.

The controlling state machine has these states: `ST_OFF` (supplies off, reset high), `ST_VDD_WAIT` (logic supply on, waiting 1 ms), `ST_RES_PULSE` (reset line low for at least 3 us), `ST_CONFIG` (command bytes), `ST_VBAT_WAIT` (panel supply on, waiting 100 ms), `ST_CLEAR` (512 zero data bytes), `ST_DISP_ON` (command 0xAF) and `ST_READY` (client writes). The transitions are:
- OFF goes to VDD_WAIT one cycle after reset is released.
- VDD_WAIT goes to RES_PULSE when its timer expires.
- RES_PULSE goes to CONFIG when its timer expires.
- CONFIG goes to VBAT_WAIT when the last command byte completes.
- VBAT_WAIT goes to CLEAR when its timer expires.
- CLEAR goes to DISP_ON when the 512th byte completes.
- DISP_ON goes to READY when 0xAF completes.
- READY is terminal until the next reset.

Top module: `oled_seq_top`

## Requirements
- R1: While `rst_n` is low, `vdd_en_n`, `vbat_en_n`, `oled_res_n` and `oled_cs_n` are 1, `oled_sclk` is 0, `ready` is 0 and `busy` is 1.
- R2: The logic supply (`vdd_en_n`, active low) is enabled first. `oled_res_n` falls no sooner than ceil(CLK_HZ/1000) cycles after it.
- R3: `oled_res_n` stays low for at least ceil(3e-6*CLK_HZ) cycles (minimum 1). It then returns high and stays high, and no byte starts while it is low.
- R4: The first five bytes are the commands 0xC0, 0xDA, 0x00, 0x20, 0x00, in that order, each with `oled_dc` = 0.
- R5: `vbat_en_n` (active low) falls only after the fifth command byte has completed. The next byte starts no sooner than ceil(CLK_HZ/10) cycles after that fall.
- R6: Next come exactly 512 bytes of value 0x00 with `oled_dc` = 1.
- R7: The byte after the clear is 0xAF with `oled_dc` = 0. `ready` is 0 until that byte has completed, then rises and stays 1.
- R8: Each byte is framed by `oled_cs_n` low and sent MSB first in SPI mode 0. `oled_sclk` idles low and has a period of SCLK_DIV clocks. `oled_mosi` and `oled_dc` are stable while the line samples them.
- R9: `wr_en` has no effect before `ready` is 1, or while `busy` is 1. No byte is sent for it.
- R10: In the ready state, `wr_en` with `busy` low sends `wr_data` once, with `oled_dc` = 1. `busy` is 1 from the next cycle until that byte has completed.
- R11: Once ready, both supplies stay enabled and `oled_res_n` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Offer a pixel byte |
| wr_data | input | 8 | Pixel byte to send |
| ready | output | 1 | Power-up finished; writes may be accepted |
| busy | output | 1 | A sequence step or a byte is in progress |
| vdd_en_n | output | 1 | Logic supply enable, active low |
| vbat_en_n | output | 1 | Panel supply enable, active low |
| oled_res_n | output | 1 | Controller reset, active low |
| oled_cs_n | output | 1 | Serial chip select, active low |
| oled_sclk | output | 1 | Serial clock, idles low |
| oled_mosi | output | 1 | Serial data, MSB first |
| oled_dc | output | 1 | 0 = command byte, 1 = pixel data byte |

## Verification
The bench decodes every byte from the serial pins and times each supply and reset edge in clock cycles. This catches a design that shortens a wait by one count, or that turns on the panel supply before the last command byte. It also catches an off-by-one in the clear counter, which would send 511 or 513 zeros. Writes are offered all through power-up and again while a byte is in flight. A design that leaks any of them puts a stray 0x5A or inverted byte on the wire. A ready flag raised at the start of 0xAF, rather than at its end, shows up in the ready value captured when each byte completes.

// File: rtl/oled_seq_pkg.sv
package oled_seq_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_VDD_WAIT,
        ST_RES_PULSE,
        ST_CONFIG,
        ST_VBAT_WAIT,
        ST_CLEAR,
        ST_DISP_ON,
        ST_READY
    } seq_state_t;

    localparam int PANEL_W     = 128;
    localparam int PANEL_H     = 32;
    localparam int CLEAR_BYTES = (PANEL_W * PANEL_H) / 8;
    localparam int CFG_LEN     = 5;
    localparam logic [7:0] CMD_DISPLAY_ON = 8'hAF;

    // configuration command list, sent in index order
    function automatic logic [7:0] cfg_byte(input logic [2:0] idx);
        logic [7:0] b;
        unique case (idx)
            3'd0:    b = 8'hC0;   // scan direction
            3'd1:    b = 8'hDA;   // COM pin setup
            3'd2:    b = 8'h00;   // its argument
            3'd3:    b = 8'h20;   // addressing mode
            3'd4:    b = 8'h00;   // horizontal
            default: b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/oled_wait_timer.sv
module oled_wait_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         zero
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/oled_byte_tx.sv
module oled_byte_tx #(
    parameter int SCLK_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] din,
    input  logic       dc_in,
    output logic       sclk,
    output logic       mosi,
    output logic       cs_n,
    output logic       dc,
    output logic       busy,
    output logic       done
);

    localparam int DIV  = (SCLK_DIV < 4) ? 4 : SCLK_DIV;
    localparam int HALF = DIV / 2;
    localparam int CW   = $clog2(DIV);

    logic [7:0]    shreg;
    logic [2:0]    bitn;
    logic [CW-1:0] phase;
    logic          active;
    logic          dc_q;
    logic          done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg  <= '0;
            bitn   <= '0;
            phase  <= '0;
            active <= 1'b0;
            dc_q   <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!active) begin
                if (start) begin
                    active <= 1'b1;
                    shreg  <= din;
                    dc_q   <= dc_in;
                    bitn   <= '0;
                    phase  <= '0;
                end
            end else if (phase == CW'(DIV - 1)) begin
                phase <= '0;
                if (bitn == 3'd7) begin
                    active <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    shreg <= {shreg[6:0], 1'b0};
                    bitn  <= bitn + 3'd1;
                end
            end else begin
                phase <= phase + 1'b1;
            end
        end
    end

    assign sclk = active && (phase >= CW'(HALF));
    assign mosi = shreg[7];
    assign cs_n = ~active;
    assign dc   = dc_q;
    assign busy = active;
    assign done = done_q;

endmodule

// File: rtl/oled_seq_top.sv
module oled_seq_top
    import oled_seq_pkg::*;
#(
    parameter int CLK_HZ   = 100_000_000,
    parameter int SCLK_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic       ready,
    output logic       busy,
    output logic       vdd_en_n,
    output logic       vbat_en_n,
    output logic       oled_res_n,
    output logic       oled_cs_n,
    output logic       oled_sclk,
    output logic       oled_mosi,
    output logic       oled_dc
);

    localparam int T_VDD   = (CLK_HZ + 999) / 1000;
    localparam int RES_RAW = (CLK_HZ / 1000000) * 3 + ((CLK_HZ % 1000000) * 3 + 999999) / 1000000;
    localparam int T_RES   = (RES_RAW < 1) ? 1 : RES_RAW;
    localparam int T_VBAT  = (CLK_HZ + 9) / 10;
    localparam int TW      = $clog2(T_VBAT + 1);
    localparam int IW      = $clog2(CLEAR_BYTES);

    seq_state_t    st, st_n;
    logic [IW-1:0] idx, idx_n;
    logic          need_go, go_n;
    logic          tmr_load, tmr_zero;
    logic [TW-1:0] tmr_val;
    logic          tx_start, tx_dc, tx_busy, tx_done;
    logic [7:0]    tx_byte;

    oled_wait_timer #(.W(TW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .val   (tmr_val),
        .zero  (tmr_zero)
    );

    oled_byte_tx #(.SCLK_DIV(SCLK_DIV)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tx_start),
        .din   (tx_byte),
        .dc_in (tx_dc),
        .sclk  (oled_sclk),
        .mosi  (oled_mosi),
        .cs_n  (oled_cs_n),
        .dc    (oled_dc),
        .busy  (tx_busy),
        .done  (tx_done)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= ST_OFF;
            idx     <= '0;
            need_go <= 1'b0;
        end else begin
            st      <= st_n;
            idx     <= idx_n;
            need_go <= go_n;
        end
    end

    // transitions
    always_comb begin
        st_n     = st;
        idx_n    = idx;
        go_n     = need_go;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (st)
            ST_OFF: begin
                st_n     = ST_VDD_WAIT;
                tmr_load = 1'b1;
                tmr_val  = TW'(T_VDD);
            end
            ST_VDD_WAIT: begin
                if (tmr_zero) begin
                    st_n     = ST_RES_PULSE;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(T_RES);
                end
            end
            ST_RES_PULSE: begin
                if (tmr_zero) begin
                    st_n  = ST_CONFIG;
                    idx_n = '0;
                    go_n  = 1'b1;
                end
            end
            ST_CONFIG: begin
                if (need_go)
                    go_n = 1'b0;
                else if (tx_done) begin
                    if (idx == IW'(CFG_LEN - 1)) begin
                        st_n     = ST_VBAT_WAIT;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(T_VBAT);
                    end else begin
                        idx_n = idx + 1'b1;
                        go_n  = 1'b1;
                    end
                end
            end
            ST_VBAT_WAIT: begin
                if (tmr_zero) begin
                    st_n  = ST_CLEAR;
                    idx_n = '0;
                    go_n  = 1'b1;
                end
            end
            ST_CLEAR: begin
                if (need_go)
                    go_n = 1'b0;
                else if (tx_done) begin
                    go_n = 1'b1;
                    if (idx == IW'(CLEAR_BYTES - 1))
                        st_n = ST_DISP_ON;
                    else
                        idx_n = idx + 1'b1;
                end
            end
            ST_DISP_ON: begin
                if (need_go)
                    go_n = 1'b0;
                else if (tx_done)
                    st_n = ST_READY;
            end
            ST_READY: begin
                st_n = ST_READY;
            end
        endcase
    end

    // outputs
    always_comb begin
        vdd_en_n   = (st == ST_OFF);
        oled_res_n = (st != ST_RES_PULSE);
        vbat_en_n  = 1'b1;
        tx_start   = need_go;
        tx_byte    = 8'h00;
        tx_dc      = 1'b0;
        unique case (st)
            ST_OFF, ST_VDD_WAIT, ST_RES_PULSE: ;
            ST_CONFIG:    tx_byte = cfg_byte(idx[2:0]);
            ST_VBAT_WAIT: vbat_en_n = 1'b0;
            ST_CLEAR: begin
                vbat_en_n = 1'b0;
                tx_dc     = 1'b1;
            end
            ST_DISP_ON: begin
                vbat_en_n = 1'b0;
                tx_byte   = CMD_DISPLAY_ON;
            end
            ST_READY: begin
                vbat_en_n = 1'b0;
                tx_byte   = wr_data;
                tx_dc     = 1'b1;
                tx_start  = wr_en && !tx_busy;
            end
        endcase
    end

    assign ready = (st == ST_READY);
    assign busy  = (st != ST_READY) || tx_busy;

endmodule

// File: rtl/oled_seq_checker.sv
module oled_seq_checker (
    input logic clk,
    input logic rst_n,
    input logic ready,
    input logic busy,
    input logic vdd_en_n,
    input logic vbat_en_n,
    input logic oled_res_n,
    input logic oled_cs_n,
    input logic oled_sclk,
    input logic oled_mosi,
    input logic oled_dc
);

    p_res_needs_vdd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !oled_res_n |-> !vdd_en_n);

    p_no_byte_in_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !oled_res_n |-> oled_cs_n);

    p_vbat_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !vbat_en_n |-> (!vdd_en_n && oled_res_n));

    p_ready_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    p_idle_clock_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        oled_cs_n |-> !oled_sclk);

    p_mosi_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (oled_sclk && $past(oled_sclk)) |-> $stable(oled_mosi));

    p_dc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!oled_cs_n && $past(!oled_cs_n)) |-> $stable(oled_dc));

    p_busy_in_byte_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !oled_cs_n) |-> busy);

    p_supplies_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (!vdd_en_n && !vbat_en_n && oled_res_n));

endmodule

bind oled_seq_top oled_seq_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ready      (ready),
    .busy       (busy),
    .vdd_en_n   (vdd_en_n),
    .vbat_en_n  (vbat_en_n),
    .oled_res_n (oled_res_n),
    .oled_cs_n  (oled_cs_n),
    .oled_sclk  (oled_sclk),
    .oled_mosi  (oled_mosi),
    .oled_dc    (oled_dc)
);

// File: tb/oled_seq_top_bench.sv
module oled_seq_top_bench;

    localparam int CLK_HZ   = 100_000;
    localparam int SCLK_DIV = 4;
    localparam int N_INIT   = 5 + 512 + 1;
    localparam int N_RAND   = 40;
    localparam int LOGN     = 1024;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       ready, busy, vdd_en_n, vbat_en_n, oled_res_n;
    logic       oled_cs_n, oled_sclk, oled_mosi, oled_dc;

    int checks = 0;
    int bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    oled_seq_top #(.CLK_HZ(CLK_HZ), .SCLK_DIV(SCLK_DIV)) u_oled_seq_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .ready      (ready),
        .busy       (busy),
        .vdd_en_n   (vdd_en_n),
        .vbat_en_n  (vbat_en_n),
        .oled_res_n (oled_res_n),
        .oled_cs_n  (oled_cs_n),
        .oled_sclk  (oled_sclk),
        .oled_mosi  (oled_mosi),
        .oled_dc    (oled_dc)
    );

    // expected timing, from the requirements
    function automatic longint exp_vdd_cyc();
        return (CLK_HZ + 999) / 1000;
    endfunction
    function automatic longint exp_res_cyc();
        longint r;
        r = (longint'(CLK_HZ) * 3 + 999999) / 1000000;
        return (r < 1) ? 1 : r;
    endfunction
    function automatic longint exp_vbat_cyc();
        return (CLK_HZ + 9) / 10;
    endfunction
    // expected power-up byte k: {dc, value}
    function automatic logic [8:0] exp_init(input int k);
        logic [7:0] cfg [0:4];
        cfg[0] = 8'hC0; cfg[1] = 8'hDA; cfg[2] = 8'h00; cfg[3] = 8'h20; cfg[4] = 8'h00;
        if (k < 5)   return {1'b0, cfg[k]};
        if (k < 517) return {1'b1, 8'h00};
        return {1'b0, 8'hAF};
    endfunction

    function automatic longint now_cyc();
        return $time / 8;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // serial monitor
    logic [7:0] lg_b   [0:LOGN-1];
    logic       lg_dc  [0:LOGN-1];
    logic       lg_rdy [0:LOGN-1];
    longint     lg_t0  [0:LOGN-1];
    longint     lg_t1  [0:LOGN-1];
    int         nlog = 0;
    int         mon_bits = 0;
    int         mon_err = 0;
    logic [7:0] mon_sh = 8'h00;
    longint     mon_start = 0;
    longint     last_rise = 0;
    bit         mon_armed = 0;
    longint     t_vdd = -1, t_resf = -1, t_resr = -1, t_vbat = -1;

    always @(negedge oled_cs_n) begin
        mon_armed = 1;
        mon_bits  = 0;
        mon_start = now_cyc();
    end
    always @(posedge oled_sclk) begin
        if (oled_cs_n === 1'b0) begin
            if (mon_bits > 0 && (now_cyc() - last_rise) != SCLK_DIV) mon_err++;
            last_rise = now_cyc();
            mon_sh    = {mon_sh[6:0], oled_mosi};
            mon_bits++;
        end
    end
    always @(posedge oled_cs_n) begin
        if (mon_armed && nlog < LOGN) begin
            if (mon_bits != 8) mon_err++;
            lg_b[nlog]   = mon_sh;
            lg_dc[nlog]  = oled_dc;
            lg_rdy[nlog] = ready;
            lg_t0[nlog]  = mon_start;
            lg_t1[nlog]  = now_cyc();
            nlog++;
        end
        mon_armed = 0;
    end
    always @(negedge vdd_en_n)   if (t_vdd < 0) t_vdd = now_cyc();
    always @(negedge oled_res_n) if (t_resf < 0) t_resf = now_cyc();
    always @(posedge oled_res_n) if (t_resf >= 0 && t_resr < 0) t_resr = now_cyc();
    always @(negedge vbat_en_n)  if (t_vbat < 0) t_vbat = now_cyc();

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", checks, bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            bad++;
            $display("FAIL watchdog: run did not complete actual=hung expected=done");
            summary();
            $finish;
        end
    end

    logic [7:0] exp_q [0:N_RAND-1];

    initial begin
        void'($urandom(32'd20250611));
        repeat (5) @(negedge clk);
        // R1 reset state
        check(vdd_en_n === 1'b1,  "R1 vdd_en_n", vdd_en_n, 1);
        check(vbat_en_n === 1'b1, "R1 vbat_en_n", vbat_en_n, 1);
        check(oled_res_n === 1'b1, "R1 oled_res_n", oled_res_n, 1);
        check(oled_cs_n === 1'b1 && oled_sclk === 1'b0, "R1 serial idle",
              {oled_cs_n, oled_sclk}, 2'b10);
        check(ready === 1'b0 && busy === 1'b1, "R1 flags", {ready, busy}, 2'b01);
        rst_n = 1'b1;

        // R9: offer writes all through power-up
        while (ready !== 1'b1) begin
            @(negedge clk);
            wr_en   = 1'($urandom % 2);
            wr_data = 8'h5A;
        end
        wr_en = 1'b0;
        repeat (3) @(negedge clk);

        check(nlog == N_INIT, "R9 bytes at ready (writes before ready ignored)", nlog, N_INIT);
        check(t_resf - t_vdd >= exp_vdd_cyc(), "R2 vdd to reset delay",
              t_resf - t_vdd, exp_vdd_cyc());
        check(t_resr - t_resf >= exp_res_cyc(), "R3 reset low width",
              t_resr - t_resf, exp_res_cyc());
        check(nlog > 0 && lg_t0[0] >= t_resr, "R3 first byte after reset",
              lg_t0[0], t_resr);
        begin
            int e4 = 0;
            for (int k = 0; k < 5; k++)
                if ({lg_dc[k], lg_b[k]} !== exp_init(k)) e4++;
            check(e4 == 0, "R4 command list", e4, 0);
        end
        check(t_vbat >= lg_t1[4], "R5 panel supply after last command", t_vbat, lg_t1[4]);
        check(lg_t0[5] - t_vbat >= exp_vbat_cyc(), "R5 settle time",
              lg_t0[5] - t_vbat, exp_vbat_cyc());
        begin
            int e6 = 0;
            for (int k = 5; k < 517; k++)
                if ({lg_dc[k], lg_b[k]} !== exp_init(k)) e6++;
            check(e6 == 0, "R6 clear bytes", e6, 0);
        end
        check({lg_dc[517], lg_b[517]} === exp_init(517), "R7 display on byte",
              {lg_dc[517], lg_b[517]}, exp_init(517));
        begin
            int er = 0;
            for (int k = 0; k < N_INIT; k++)
                if (lg_rdy[k] !== 1'b0) er++;
            check(er == 0, "R7 ready low until 0xAF done", er, 0);
        end
        check(ready === 1'b1 && busy === 1'b0, "R7 ready after power-up",
              {ready, busy}, 2'b10);

        // R10 / R9: writes in ready state, with some offered while busy
        for (int n = 0; n < N_RAND; n++) begin
            logic [7:0] d;
            case (n)
                0: d = 8'h00;
                1: d = 8'hFF;
                2: d = 8'h80;
                3: d = 8'h01;
                default: d = 8'($urandom);
            endcase
            exp_q[n] = d;
            while (busy) @(negedge clk);
            wr_en   = 1'b1;
            wr_data = d;
            @(negedge clk);
            wr_en = 1'b0;
            check(busy === 1'b1, "R10 busy after accept", busy, 1);
            if (n % 5 == 0) begin
                @(negedge clk);
                wr_en   = 1'b1;
                wr_data = ~d;
                @(negedge clk);
                wr_en = 1'b0;
            end
        end
        while (busy) @(negedge clk);
        repeat (10) @(negedge clk);

        check(nlog == N_INIT + N_RAND, "R9 no byte for writes while busy",
              nlog, N_INIT + N_RAND);
        begin
            int e10 = 0;
            for (int n = 0; n < N_RAND; n++)
                if ({lg_dc[N_INIT + n], lg_b[N_INIT + n]} !== {1'b1, exp_q[n]}) begin
                    e10++;
                    $display("FAIL R10 byte %0d actual=%0h expected=%0h", n,
                             {lg_dc[N_INIT + n], lg_b[N_INIT + n]}, {1'b1, exp_q[n]});
                end
            check(e10 == 0, "R10 written bytes", e10, 0);
        end
        check(mon_err == 0, "R8 framing and clock period", mon_err, 0);
        check(vdd_en_n === 1'b0 && vbat_en_n === 1'b0 && oled_res_n === 1'b1,
              "R11 supplies held", {vdd_en_n, vbat_en_n, oled_res_n}, 3'b001);
        check(ready === 1'b1, "R7 ready stays", ready, 1);

        finished = 1;
        summary();
        $finish;
    end

endmodule